// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire (I2C-style) serial memory. It runs on a fast system clock. Each of the two bus lines passes through a synchronizer and a short stable-count filter before edge detection. The slave finds start and stop conditions, shifts bytes in on SCL rising edges, and shifts bytes out after SCL falling edges. It answers the device address `1010` followed by the three chip-select pins, and it pulls SDA low only through an open-drain enable. A word address counter sets where reads and writes land. Current-address, random (a dummy write, then a repeated start) and sequential reads are supported.

Write bytes go into an 8-byte page buffer inside a separate store. A stop after at least one data byte starts an internal write cycle of `WRITE_CYCLES` clocks. During that cycle the slave does not acknowledge its own address, so a master can poll for completion. The cell array is a register file of `MEM_BYTES` (128 or 256) bytes. With 128 bytes, the top bit of the word address byte is ignored. A start, nine SCL pulses with SDA high and a second start together form a software reset, which returns the word counter to 00h.

The controller has ten states:

| State | Meaning |
|---|---|
| IDLE | Standby |
| DEV | Receiving the device byte |
| DEV_ACK | Acknowledging the device byte |
| WADDR | Receiving the word address |
| WADDR_ACK | Acknowledging the word address |
| WDATA | Receiving a write data byte |
| WDATA_ACK | Acknowledging a write data byte |
| RDATA | Sending a read byte |
| RACK | Sampling the master's acknowledge |
| IGNORE | Bus released until the next start or stop |

Transitions:
- Any state goes to DEV on a start and to IDLE on a stop.
- DEV goes to DEV_ACK on the 8th falling edge when the header matches and no write cycle is running; otherwise it goes to IGNORE.
- DEV_ACK goes to RDATA for a read header or to WADDR for a write header.
- WADDR goes to WADDR_ACK, and WADDR_ACK goes to WDATA.
- WDATA and WDATA_ACK alternate for each data byte.
- RDATA goes to RACK. RACK goes back to RDATA on a low acknowledge, or to IGNORE when there is none.

Top module: `twsm_slave`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A stop returns the slave to IDLE from any state. A start begins decoding a new device byte.
- R2: The first byte after a start is sent MSB first as `1010`, A2, A1, A0, R/W (1 = read). When the header matches `chip_sel_i` = {A2,A1,A0}, the slave drives SDA low during the 9th clock.
- R3: On a header mismatch the slave gives no acknowledge and leaves SDA released until the next start. After reset, SDA is released.
- R4: In a write, the word address byte and each data byte are acknowledged. After the stop, each byte is stored at the next address. Only the low three address bits advance, wrapping within the 8-byte page, and when more than 8 bytes arrive the last 8 are kept.
- R5: From the stop that ends a write until the write cycle ends, the device byte is not acknowledged in either direction. After the cycle ends it is acknowledged again.
- R6: A current-address read returns the byte one past the last byte accessed. After power-up reset the counter is 00h.
- R7: A random read (write header, one word address byte, repeated start, read header) returns the byte at that word address.
- R8: In a sequential read, a low acknowledge from the master brings the next byte. The address advances at the fall of each last data bit and wraps from the top address to 0.
- R9: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing more before the stop.
- R10: A start in the middle of a write instruction discards it: nothing is stored and no write cycle begins.
- R11: A start, nine SCL pulses with SDA high and then a start set the word counter to 00h.
- R12: A pulse on SCL or SDA shorter than `FILT_LEN` system clocks does not reach the decoder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low power-up reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (the resolved bus) |
| chip_sel_i | input | 3 | Chip-select pins {A2,A1,A0} |
| sda_pull_low_o | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
The software reset is the hardest state to reach from the pins. It counts only complete SCL pulses with SDA high that come between two starts, and a normal transfer must never satisfy that count. The bench first moves the counter away from zero with a random read. It then sends a start, nine released clocks and a second start, and reads the current address to confirm it returns to 00h. Busy-time polling is reached by sending a header right after the stop of a write, well inside the write cycle, and again after the cycle has ended.

// File: rtl/twsm_pkg.sv
package twsm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } twsm_state_e;

    localparam logic [3:0] DEV_CODE     = 4'b1010;
    localparam int         RESET_PULSES = 9;
    localparam int         BYTE_BITS    = 8;

endpackage

// File: rtl/twsm_deglitch.sv
module twsm_deglitch #(
    parameter int STAGES   = 2,
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [STAGES-1:0] sync_q;
    logic [CW-1:0]     cnt_q;
    logic              clean_q;
    logic              samp;

    assign samp    = sync_q[STAGES-1];
    assign clean_o = clean_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= '1;
            cnt_q   <= '0;
            clean_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], raw_i};
            if (samp == clean_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_LEN - 1)) begin
                clean_q <= samp;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // A change of the filtered level needs at least two agreeing samples before it.
    assert_filter_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (clean_q != $past(clean_q)) |-> (($past(samp) == clean_q) && ($past(samp, 2) == clean_q)));

endmodule

// File: rtl/twsm_bus_events.sv
module twsm_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise_o = !scl_q && scl_i;
    assign scl_fall_o = scl_q && !scl_i;
    assign start_o    = scl_q && scl_i && sda_q && !sda_i;
    assign stop_o     = scl_q && scl_i && !sda_q && sda_i;

endmodule

// File: rtl/twsm_store.sv
module twsm_store #(
    parameter int MEM_BYTES    = 256,
    parameter int PAGE_BYTES   = 8,
    parameter int WRITE_CYCLES = 2000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  logic [$clog2(MEM_BYTES)-1:0] push_addr_i,
    input  logic [7:0]                   push_data_i,
    input  logic                         commit_i,
    input  logic                         discard_i,
    input  logic [$clog2(MEM_BYTES)-1:0] rd_addr_i,
    output logic [7:0]                   rd_data_o,
    output logic                         busy_o
);
    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int TW = $clog2(WRITE_CYCLES + 1);

    logic [7:0]         cells_q [MEM_BYTES];
    logic [7:0]         pbuf_q  [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pvalid_q;
    logic [AW-PW-1:0]   pbase_q;
    logic               busy_q;
    logic [TW-1:0]      tmr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) cells_q[i] <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) pbuf_q[i] <= '0;
            pvalid_q <= '0;
            pbase_q  <= '0;
            busy_q   <= 1'b0;
            tmr_q    <= '0;
        end else if (busy_q) begin
            tmr_q <= tmr_q - 1'b1;
            if (tmr_q == TW'(1)) begin
                busy_q <= 1'b0;
                for (int i = 0; i < PAGE_BYTES; i++) begin
                    if (pvalid_q[i]) cells_q[{pbase_q, PW'(i)}] <= pbuf_q[i];
                end
                pvalid_q <= '0;
            end
        end else if (commit_i && (|pvalid_q)) begin
            busy_q <= 1'b1;
            tmr_q  <= TW'(WRITE_CYCLES);
        end else if (discard_i) begin
            pvalid_q <= '0;
        end else if (push_i) begin
            pbuf_q[push_addr_i[PW-1:0]]   <= push_data_i;
            pvalid_q[push_addr_i[PW-1:0]] <= 1'b1;
            pbase_q                       <= push_addr_i[AW-1:PW];
        end
    end

    assign rd_data_o = cells_q[rd_addr_i];
    assign busy_o    = busy_q;

    // No byte may reach the page buffer while its contents are being committed.
    assert_push_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !busy_q);

endmodule

// File: rtl/twsm_slave.sv
module twsm_slave
    import twsm_pkg::*;
#(
    parameter int MEM_BYTES    = 256,
    parameter int PAGE_BYTES   = 8,
    parameter int WRITE_CYCLES = 2000,
    parameter int SYNC_STAGES  = 2,
    parameter int FILT_LEN     = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] chip_sel_i,
    output logic       sda_pull_low_o
);
    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);

    // ---------------- line conditioning ----------------
    logic [1:0] raw_lines;
    logic [1:0] clean_lines;
    logic       scl_f, sda_f;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        twsm_deglitch #(.STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_lines[g]),
            .clean_o(clean_lines[g])
        );
    end

    assign scl_f = clean_lines[1];
    assign sda_f = clean_lines[0];

    logic scl_rise, scl_fall, start_ev, stop_ev;

    twsm_bus_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_f),
        .sda_i     (sda_f),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (start_ev),
        .stop_o    (stop_ev)
    );

    // ---------------- state and datapath ----------------
    twsm_state_e state_q, state_d;
    logic [3:0]  bit_cnt_q;
    logic [7:0]  rx_q;
    logic [7:0]  tx_q;
    logic        rw_q;
    logic        mack_q;
    logic        got_data_q;
    logic [AW-1:0] addr_q;

    logic [3:0]  rst_cnt_q;
    logic        rst_ok_q;
    logic        rst_rose_q;
    logic        sw_reset;

    logic        byte_done;
    logic        hdr_ok;
    logic        busy;
    logic        push;
    logic        commit;
    logic [7:0]  rd_data;

    assign byte_done = scl_fall && (bit_cnt_q == 4'(BYTE_BITS));
    assign hdr_ok    = (rx_q[7:4] == DEV_CODE) && (rx_q[3:1] == chip_sel_i);
    assign sw_reset  = start_ev && rst_ok_q && (rst_cnt_q == 4'(RESET_PULSES));
    assign push      = byte_done && (state_q == ST_WDATA);
    assign commit    = stop_ev && got_data_q &&
                       ((state_q == ST_WDATA) || (state_q == ST_WDATA_ACK));

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_ev) begin
            state_d = ST_IDLE;
        end else if (start_ev) begin
            state_d = ST_DEV;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: state_d = state_q;
                ST_DEV:       if (byte_done) state_d = (hdr_ok && !busy) ? ST_DEV_ACK : ST_IGNORE;
                ST_DEV_ACK:   if (scl_fall)  state_d = rw_q ? ST_RDATA : ST_WADDR;
                ST_WADDR:     if (byte_done) state_d = ST_WADDR_ACK;
                ST_WADDR_ACK: if (scl_fall)  state_d = ST_WDATA;
                ST_WDATA:     if (byte_done) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall)  state_d = ST_WDATA;
                ST_RDATA:     if (byte_done) state_d = ST_RACK;
                ST_RACK:      if (scl_fall)  state_d = mack_q ? ST_RDATA : ST_IGNORE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // shift registers, counters and the word address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q  <= '0;
            rx_q       <= '0;
            tx_q       <= '0;
            rw_q       <= 1'b0;
            mack_q     <= 1'b0;
            got_data_q <= 1'b0;
            addr_q     <= '0;
        end else if (start_ev) begin
            bit_cnt_q  <= '0;
            got_data_q <= 1'b0;
            if (sw_reset) addr_q <= '0;
        end else begin
            if (scl_rise) begin
                unique case (state_q)
                    ST_DEV, ST_WADDR, ST_WDATA: begin
                        rx_q      <= {rx_q[6:0], sda_f};
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end
                    ST_RDATA: bit_cnt_q <= bit_cnt_q + 1'b1;
                    ST_RACK:  mack_q    <= !sda_f;
                    default:  ;
                endcase
            end
            if (scl_fall) begin
                unique case (state_q)
                    ST_DEV: if (byte_done) begin
                        rw_q      <= rx_q[0];
                        bit_cnt_q <= '0;
                    end
                    ST_DEV_ACK: begin
                        bit_cnt_q <= '0;
                        if (rw_q) tx_q <= rd_data;
                    end
                    ST_WADDR: if (byte_done) begin
                        addr_q    <= rx_q[AW-1:0];
                        bit_cnt_q <= '0;
                    end
                    ST_WDATA: if (byte_done) begin
                        addr_q     <= {addr_q[AW-1:PW], addr_q[PW-1:0] + 1'b1};
                        got_data_q <= 1'b1;
                        bit_cnt_q  <= '0;
                    end
                    ST_RDATA: begin
                        if (byte_done) begin
                            addr_q    <= addr_q + 1'b1;
                            bit_cnt_q <= '0;
                        end else begin
                            tx_q <= {tx_q[6:0], 1'b1};
                        end
                    end
                    ST_RACK: begin
                        tx_q      <= rd_data;
                        bit_cnt_q <= '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // software reset tracker: complete SCL pulses with SDA high since the last start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_cnt_q  <= '0;
            rst_ok_q   <= 1'b0;
            rst_rose_q <= 1'b0;
        end else if (start_ev) begin
            rst_cnt_q  <= '0;
            rst_ok_q   <= 1'b1;
            rst_rose_q <= 1'b0;
        end else begin
            if (scl_rise) begin
                rst_rose_q <= 1'b1;
                if (!sda_f) rst_ok_q <= 1'b0;
            end
            if (scl_fall && rst_rose_q && (rst_cnt_q != 4'hF)) begin
                rst_cnt_q <= rst_cnt_q + 1'b1;
            end
        end
    end

    // output decode
    always_comb begin
        unique case (state_q)
            ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: sda_pull_low_o = 1'b1;
            ST_RDATA: sda_pull_low_o = !tx_q[7];
            default:  sda_pull_low_o = 1'b0;
        endcase
    end

    twsm_store #(
        .MEM_BYTES   (MEM_BYTES),
        .PAGE_BYTES  (PAGE_BYTES),
        .WRITE_CYCLES(WRITE_CYCLES)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push),
        .push_addr_i(addr_q),
        .push_data_i(rx_q),
        .commit_i   (commit),
        .discard_i  (start_ev),
        .rd_addr_i  (addr_q),
        .rd_data_o  (rd_data),
        .busy_o     (busy)
    );

    assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state_q == ST_IDLE));

    assert_start_decode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> ((state_q == ST_DEV) && (bit_cnt_q == 4'd0)));

    assert_busy_no_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEV_ACK) |-> !busy);

    assert_read_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RDATA) && byte_done && (addr_q == {AW{1'b1}})) |=> (addr_q == '0));

    assert_swrst_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (addr_q == '0));

endmodule

// File: tb/test_twsm_slave.sv
`timescale 1ns/1ps
module test_twsm_slave;
    localparam int          Q     = 10;
    localparam int          WCYC  = 1000;
    localparam logic [2:0]  SEL   = 3'b101;
    localparam logic [7:0]  HDR_W = {4'b1010, SEL, 1'b0};
    localparam logic [7:0]  HDR_R = {4'b1010, SEL, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull_low;
    logic sda_line;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] model [256];
    int exp_ptr = 0;

    always #2.5 clk = ~clk;
    assign sda_line = sda_m & ~sda_pull_low;

    twsm_slave #(.WRITE_CYCLES(WCYC)) i_twsm_slave (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl_m),
        .sda_i         (sda_line),
        .chip_sel_i    (SEL),
        .sda_pull_low_o(sda_pull_low)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bit_x(input logic b, input bit gl, output logic s);
        tick(Q);
        sda_m = b;
        tick(Q / 2);
        if (gl) begin
            scl_m = 1'b1;
            tick(1);
            scl_m = 1'b0;
        end
        tick(Q / 2);
        scl_m = 1'b1;
        tick(Q);
        s = sda_line;
        tick(Q);
        scl_m = 1'b0;
    endtask

    task automatic start_c();
        tick(Q); sda_m = 1'b1;
        tick(Q); scl_m = 1'b1;
        tick(Q); sda_m = 1'b0;
        tick(Q); scl_m = 1'b0;
    endtask

    task automatic stop_c();
        tick(Q); sda_m = 1'b0;
        tick(Q); scl_m = 1'b1;
        tick(Q); sda_m = 1'b1;
        tick(2 * Q);
    endtask

    task automatic wbyte(input logic [7:0] b, input bit gl, output bit ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_x(b[i], gl, s);
        bit_x(1'b1, 1'b0, s);
        ack = !s;
    endtask

    task automatic rbyte(input bit give_ack, output logic [7:0] d);
        logic s;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            bit_x(1'b1, 1'b0, s);
            d = {d[6:0], s};
        end
        bit_x(!give_ack, 1'b0, s);
    endtask

    task automatic xfer_write(input logic [7:0] a, input int n, input logic [7:0] first, input string tag);
        bit ack;
        start_c();
        wbyte(HDR_W, 1'b0, ack);
        check(ack, {tag, " R1 R2 header ack"}, ack, 1);
        wbyte(a, 1'b0, ack);
        check(ack, {tag, " R4 word address ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = first + 8'(i);
            wbyte(d, 1'b0, ack);
            check(ack, {tag, " R4 data ack"}, ack, 1);
            model[(int'(a) & 'hF8) | ((int'(a) + i) & 7)] = d;
        end
        exp_ptr = (int'(a) & 'hF8) | ((int'(a) + n) & 7);
        stop_c();
    endtask

    task automatic read_seq(input bit rnd, input logic [7:0] a, input int n, input bit gl, input string tag);
        bit ack;
        logic [7:0] d;
        if (rnd) begin
            start_c();
            wbyte(HDR_W, gl, ack);
            check(ack, {tag, " R7 dummy header ack"}, ack, 1);
            wbyte(a, gl, ack);
            check(ack, {tag, " R7 address ack"}, ack, 1);
            exp_ptr = int'(a);
        end
        start_c();
        wbyte(HDR_R, gl, ack);
        check(ack, {tag, " R2 read header ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            rbyte(i < n - 1, d);
            check(d == model[exp_ptr], {tag, " data"}, d, model[exp_ptr]);
            exp_ptr = (exp_ptr + 1) & 255;
        end
        tick(Q);
        check(sda_pull_low == 1'b0, {tag, " R9 released after no-ack"}, sda_pull_low, 0);
        stop_c();
    endtask

    task automatic poll(input bit expect_ack, input string tag);
        bit ack;
        start_c();
        wbyte(HDR_W, 1'b0, ack);
        check(ack == expect_ack, tag, ack, expect_ack);
        stop_c();
    endtask

    task automatic t_reset();
        check(sda_pull_low == 1'b0, "R3 released after reset", sda_pull_low, 0);
        read_seq(1'b0, 8'h00, 1, 1'b0, "R6 power-up counter at 00h");
    endtask

    task automatic t_byte_write();
        xfer_write(8'h10, 1, 8'hA5, "byte write");
        poll(1'b0, "R5 no ack while write cycle runs");
        tick(WCYC + 100);
        poll(1'b1, "R5 ack after write cycle");
        xfer_write(8'h00, 1, 8'h5C, "byte write at 00h");
        tick(WCYC + 100);
    endtask

    task automatic t_random_read();
        read_seq(1'b1, 8'h10, 1, 1'b0, "R7 random read");
    endtask

    task automatic t_page_write();
        xfer_write(8'h1E, 10, 8'h40, "R4 page write with wrap");
        tick(WCYC + 100);
        read_seq(1'b1, 8'h18, 6, 1'b0, "R4 R8 page contents");
        read_seq(1'b0, 8'h00, 1, 1'b0, "R6 current address");
    endtask

    task automatic t_wrap();
        xfer_write(8'hFE, 2, 8'h77, "top page write");
        tick(WCYC + 100);
        read_seq(1'b1, 8'hFE, 3, 1'b0, "R8 wrap to 0");
    endtask

    task automatic t_mismatch();
        bit ack;
        logic [7:0] d;
        start_c();
        wbyte({4'b1010, 3'b011, 1'b1}, 1'b0, ack);
        check(!ack, "R3 wrong chip select not acked", ack, 0);
        rbyte(1'b0, d);
        check(d == 8'hFF, "R3 bus stays released", d, 8'hFF);
        stop_c();
        start_c();
        wbyte({4'b1011, SEL, 1'b0}, 1'b0, ack);
        check(!ack, "R3 wrong device code not acked", ack, 0);
        stop_c();
    endtask

    task automatic t_abort();
        bit ack;
        start_c();
        wbyte(HDR_W, 1'b0, ack);
        check(ack, "R10 header ack", ack, 1);
        wbyte(8'h30, 1'b0, ack);
        check(ack, "R10 address ack", ack, 1);
        wbyte(8'h99, 1'b0, ack);
        check(ack, "R10 data ack", ack, 1);
        start_c();
        stop_c();
        poll(1'b1, "R10 no write cycle after aborted write");
        read_seq(1'b1, 8'h30, 1, 1'b0, "R10 aborted byte not stored");
    endtask

    task automatic t_sw_reset();
        logic s;
        read_seq(1'b1, 8'h18, 1, 1'b0, "R11 move counter");
        start_c();
        for (int i = 0; i < 9; i++) bit_x(1'b1, 1'b0, s);
        start_c();
        stop_c();
        exp_ptr = 0;
        check(sda_pull_low == 1'b0, "R11 released after reset sequence", sda_pull_low, 0);
        read_seq(1'b0, 8'h00, 1, 1'b0, "R11 counter back at 00h");
    endtask

    task automatic t_glitch();
        read_seq(1'b1, 8'h10, 1, 1'b1, "R12 SCL glitches rejected");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        tick(10);
        rst_n = 1'b1;
        tick(10);
        t_reset();
        t_byte_write();
        t_random_read();
        t_page_write();
        t_wrap();
        t_mismatch();
        t_abort();
        t_sw_reset();
        t_glitch();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule